// File: doc/BRIEF.md
# I2S Stereo Receive Channel

This block receives one stereo pair of audio samples per frame from a three-wire I2S link (bit clock, word select, serial data) driven by an external clock master. It samples the three serial lines in its own system clock domain and picks out the rising edges of the bit clock. A state machine then assembles a left word while word select is low and a right word while it is high. Each completed pair goes into a receive FIFO, and software takes it out through two buffer registers on a simple 32-bit register bus.

Software chooses the sample resolution (16, 24 or 32 bits) by writing a code. It also sets a FIFO trigger level, masks or unmasks two interrupt sources, flushes the FIFO, and starts or stops reception with three enables. Reception runs only while the global, receiver and channel enables are all set. The interrupt pin combines the unmasked data-available and overrun conditions.

The deserializer has five states. `S_IDLE` waits for a falling word-select edge, which marks the start of a frame. `S_LEFT` shifts in the left word. `S_WAIT_R` waits for the rising word-select edge. `S_RIGHT` shifts in the right word. `S_WAIT_L` waits for the next falling edge. A falling edge moves any running state to `S_LEFT`. A rising edge moves `S_WAIT_R` to `S_RIGHT`, and so does a rising edge in the same bit where the left word completes. A rising edge in any other state returns the machine to `S_IDLE`. Completing a word moves `S_LEFT` to `S_WAIT_R` and `S_RIGHT` to `S_WAIT_L`. Clearing any enable forces `S_IDLE`.

Top module: `i2s_rx_chan`

## Requirements
- R1: After reset the status register (0x038) reads 0, the mask register (0x03C) reads 3 (both interrupts masked), the resolution register (0x030) reads code 5, and irq is low.
- R2: With resolution code 2, the first 16 bits after the one-bit delay are captured MSB first. Bus reads of the left (0x020) and right (0x024) buffers return them zero-extended, and bits later in the slot are ignored.
- R3: Code 4 captures 24-bit words and code 5 captures 32-bit words, each zero-extended when read.
- R4: A write of any other code to the resolution register leaves its previous value unchanged.
- R5: Pairs leave the FIFO in arrival order. A read of the right buffer pops the head pair. Reads of either buffer return 0 while the FIFO is empty.
- R6: Status bit 0 (data available) is set while FIFO occupancy is at least the trigger level (0x048) plus one. It drives irq unless mask bit 0 is set.
- R7: A pair that completes while the FIFO (8 entries) is full is dropped and sets status bit 1 (overrun). Overrun drives irq unless mask bit 1 is set.
- R8: A read of the overrun register (0x040) returns the overrun flag in bit 0 and clears it.
- R9: Writing 1 to bit 0 of the flush register (0x010) empties the FIFO.
- R10: No pair is captured unless the global (0x000), receiver (0x004) and channel (0x028) enables are all 1.
- R11: The bit sampled on the bit-clock rise where word select changes belongs to the previous word, so the MSB of a new word comes one bit clock after the word-select edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; applies read side effects |
| reg_addr | input | 9 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| bit_clk | input | 1 | Serial bit clock from the external master |
| word_sel | input | 1 | Word select: low for left, high for right |
| ser_data | input | 1 | Serial audio data |
| irq | output | 1 | Combined unmasked receive interrupt |

## Verification
Capture is exercised at all three resolutions. Known words are sent with the unused slot bits driven to ones, which separates correct left-justified, zero-extended capture from capture at the wrong bit count. At 32 bits each word's LSB arrives only after word select has changed, which shows whether the machine keeps that bit with the old word rather than starting the new word one bit early. Long runs of distinct frames show that FIFO order is kept, and the occupancy at which data-available first appears shows whether the trigger level is off by one. A ninth frame into the full FIFO shows whether the newest sample is dropped or the oldest is overwritten. Streams sent with one enable cleared show that each enable gates capture on its own.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEFT,
        S_WAIT_R,
        S_RIGHT,
        S_WAIT_L
    } rx_state_t;

    localparam int unsigned OFS_GLOBAL_EN = 'h000;
    localparam int unsigned OFS_RX_EN     = 'h004;
    localparam int unsigned OFS_FLUSH     = 'h010;
    localparam int unsigned OFS_LEFT_BUF  = 'h020;
    localparam int unsigned OFS_RIGHT_BUF = 'h024;
    localparam int unsigned OFS_CHAN_EN   = 'h028;
    localparam int unsigned OFS_RES       = 'h030;
    localparam int unsigned OFS_STATUS    = 'h038;
    localparam int unsigned OFS_MASK      = 'h03C;
    localparam int unsigned OFS_OVR_CLR   = 'h040;
    localparam int unsigned OFS_TRIG      = 'h048;

    localparam logic [2:0] RES_CODE_16 = 3'd2;
    localparam logic [2:0] RES_CODE_24 = 3'd4;
    localparam logic [2:0] RES_CODE_32 = 3'd5;

    function automatic logic code_ok(input logic [2:0] code);
        return (code == RES_CODE_16) || (code == RES_CODE_24) || (code == RES_CODE_32);
    endfunction

    function automatic logic [5:0] code_bits(input logic [2:0] code);
        logic [5:0] n;
        unique case (code)
            RES_CODE_16: n = 6'd16;
            RES_CODE_24: n = 6'd24;
            default:     n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic rise_o,
    output logic ws_o,
    output logic sd_o
);
    localparam int W = 3;

    logic [W-1:0] pipe [STAGES];
    logic         sck_last;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= {sck_i, ws_i, sd_i};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= pipe[STAGES-1][2];
    end

    assign rise_o = pipe[STAGES-1][2] & ~sck_last;
    assign ws_o   = pipe[STAGES-1][1];
    assign sd_o   = pipe[STAGES-1][0];

endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
    import i2s_rx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          ws_i,
    input  logic          sd_i,
    input  logic [5:0]    nbits_i,
    output logic          push_o,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] right_o
);
    rx_state_t     state, nxt;
    logic          ws_q;
    logic [5:0]    cnt;
    logic [DW-1:0] sr, sr_shift, left_hold, right_q;
    logic          push_q;
    logic          capturing, done, ws_edge;

    assign capturing = (state == S_LEFT) || (state == S_RIGHT);
    assign done      = capturing && (cnt == nbits_i - 6'd1);
    assign ws_edge   = ws_i != ws_q;
    assign sr_shift  = {sr[DW-2:0], sd_i};

    always_comb begin
        nxt = state;
        if (!run_i) begin
            nxt = S_IDLE;
        end else if (tick_i) begin
            if (ws_edge) begin
                if (!ws_i)
                    nxt = S_LEFT;
                else if (state == S_WAIT_R || (state == S_LEFT && done))
                    nxt = S_RIGHT;
                else
                    nxt = S_IDLE;
            end else if (done) begin
                unique case (state)
                    S_LEFT:  nxt = S_WAIT_R;
                    S_RIGHT: nxt = S_WAIT_L;
                    default: nxt = state;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q      <= 1'b0;
            cnt       <= '0;
            sr        <= '0;
            left_hold <= '0;
            right_q   <= '0;
            push_q    <= 1'b0;
        end else begin
            push_q <= 1'b0;
            if (tick_i) begin
                ws_q <= ws_i;
                if (run_i && capturing) begin
                    sr  <= sr_shift;
                    cnt <= cnt + 6'd1;
                    if (done && state == S_LEFT) left_hold <= sr_shift;
                    if (done && state == S_RIGHT) begin
                        right_q <= sr_shift;
                        push_q  <= 1'b1;
                    end
                end
                if (run_i && ws_edge && (nxt == S_LEFT || nxt == S_RIGHT)) begin
                    sr  <= '0;
                    cnt <= '0;
                end
            end
        end
    end

    assign push_o  = push_q;
    assign left_o  = left_hold;
    assign right_o = right_q;

    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> state == S_IDLE);

    a_r10_push_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(run_i));

endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       push_i,
    input  logic [DW-1:0]              wdata_i,
    input  logic                       pop_i,
    output logic [DW-1:0]              head_o,
    output logic [$clog2(DEPTH):0]     count_o,
    output logic                       full_o,
    output logic                       empty_o
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full_o  = cnt == (AW+1)'(DEPTH);
    assign empty_o = cnt == '0;
    assign do_push = push_i && !full_o && !flush_i;
    assign do_pop  = pop_i && !empty_o && !flush_i;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush_i) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    assign head_o  = empty_o ? '0 : mem[rp];
    assign count_o = cnt;

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

endmodule

// File: rtl/i2s_rx_chan.sv
module i2s_rx_chan
    import i2s_rx_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DW         = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bit_clk,
    input  logic              word_sel,
    input  logic              ser_data,
    output logic              irq
);
    localparam int AW = $clog2(FIFO_DEPTH);

    logic          glb_en, rx_en, ch_en;
    logic [2:0]    res_code;
    logic [1:0]    mask_q;
    logic [AW-1:0] trig_q;
    logic          ovr_q;

    logic          tick, ws_s, sd_s, run;
    logic          push;
    logic [DW-1:0] left_w, right_w;
    logic [2*DW-1:0] head;
    logic [AW:0]   occ;
    logic          full, empty;
    logic          flush, pop, ovr_set, ovr_rd, avail;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign run     = glb_en & rx_en & ch_en;
    assign flush   = reg_wr && hit(reg_addr, OFS_FLUSH) && reg_wdata[0];
    assign pop     = reg_rd && hit(reg_addr, OFS_RIGHT_BUF);
    assign ovr_rd  = reg_rd && hit(reg_addr, OFS_OVR_CLR);
    assign ovr_set = push && full && !flush;
    assign avail   = occ >= ({1'b0, trig_q} + (AW+1)'(1));
    assign irq     = (avail & ~mask_q[0]) | (ovr_q & ~mask_q[1]);

    i2s_rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (bit_clk),
        .ws_i   (word_sel),
        .sd_i   (ser_data),
        .rise_o (tick),
        .ws_o   (ws_s),
        .sd_o   (sd_s)
    );

    i2s_rx_deser #(.DW(DW)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .tick_i  (tick),
        .ws_i    (ws_s),
        .sd_i    (sd_s),
        .nbits_i (code_bits(res_code)),
        .push_o  (push),
        .left_o  (left_w),
        .right_o (right_w)
    );

    i2s_rx_fifo #(.DW(2*DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .push_i  (push),
        .wdata_i ({left_w, right_w}),
        .pop_i   (pop),
        .head_o  (head),
        .count_o (occ),
        .full_o  (full),
        .empty_o (empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en   <= 1'b0;
            rx_en    <= 1'b0;
            ch_en    <= 1'b0;
            res_code <= RES_CODE_32;
            mask_q   <= 2'b11;
            trig_q   <= '0;
        end else if (reg_wr) begin
            if (hit(reg_addr, OFS_GLOBAL_EN)) glb_en <= reg_wdata[0];
            if (hit(reg_addr, OFS_RX_EN))     rx_en  <= reg_wdata[0];
            if (hit(reg_addr, OFS_CHAN_EN))   ch_en  <= reg_wdata[0];
            if (hit(reg_addr, OFS_RES) && code_ok(reg_wdata[2:0])) res_code <= reg_wdata[2:0];
            if (hit(reg_addr, OFS_MASK))      mask_q <= reg_wdata[1:0];
            if (hit(reg_addr, OFS_TRIG))      trig_q <= reg_wdata[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
        else if (ovr_rd)  ovr_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        if (hit(reg_addr, OFS_GLOBAL_EN)) reg_rdata[0] = glb_en;
        if (hit(reg_addr, OFS_RX_EN))     reg_rdata[0] = rx_en;
        if (hit(reg_addr, OFS_CHAN_EN))   reg_rdata[0] = ch_en;
        if (hit(reg_addr, OFS_LEFT_BUF))  reg_rdata = head[2*DW-1 -: 32];
        if (hit(reg_addr, OFS_RIGHT_BUF)) reg_rdata = head[DW-1 -: 32];
        if (hit(reg_addr, OFS_RES))       reg_rdata[2:0] = res_code;
        if (hit(reg_addr, OFS_STATUS))    reg_rdata[1:0] = {ovr_q, avail};
        if (hit(reg_addr, OFS_MASK))      reg_rdata[1:0] = mask_q;
        if (hit(reg_addr, OFS_OVR_CLR))   reg_rdata[0] = ovr_q;
        if (hit(reg_addr, OFS_TRIG))      reg_rdata[AW-1:0] = trig_q;
    end

    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush) |=> ovr_q);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit(reg_addr, OFS_OVR_CLR) && !(push && full)) |=> !ovr_q);

    a_r6_irq_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b11) |-> !irq);

endmodule

// File: tb/sim_i2s_rx_chan.sv
module sim_i2s_rx_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_clk = 1'b1, word_sel = 1'b1, ser_data = 1'b0;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int res_n = 32;
    logic carry = 1'b0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    i2s_rx_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_clk(bit_clk), .word_sel(word_sel), .ser_data(ser_data), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic send_bit(input logic ws, input logic b);
        @(posedge clk); #1 bit_clk = 1'b0; word_sel = ws; ser_data = b;
        repeat (4) @(posedge clk);
        #1 bit_clk = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic send_slot(input logic ws, input logic [31:0] w);
        for (int i = 0; i < 32; i++) begin
            if (i == 0)          send_bit(ws, carry);
            else if (i <= res_n) send_bit(ws, w[res_n-i]);
            else                 send_bit(ws, 1'b1);
        end
        carry = (res_n == 32) ? w[0] : 1'b1;
    endtask

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
        send_slot(1'b0, l);
        send_slot(1'b1, r);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
    endtask

    task automatic resync(input logic [2:0] code, input int n);
        res_n = n;
        wr(9'h028, 0); wr(9'h030, {29'd0, code}); wr(9'h028, 1); wr(9'h010, 1);
        carry = 1'b0;
        send_slot(1'b1, 32'd0);
    endtask

    function automatic logic [31:0] pat(input int k, input int n);
        logic [31:0] v = 32'h9E37_79B9 * (k + 3);
        return (n == 32) ? v : (v & ((32'd1 << n) - 1));
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(9'h038, d); check("R1 status after reset", d, 0);
        rd(9'h03C, d); check("R1 mask after reset", d, 3);
        rd(9'h030, d); check("R1 resolution after reset", d, 5);
        #1 check("R1 irq after reset", {31'd0, irq}, 0);
    endtask

    task automatic t_res16();
        logic [31:0] d;
        wr(9'h000, 1); wr(9'h004, 1); wr(9'h048, 0);
        resync(3'd2, 16);
        send_frame(32'h0000_A5C3, 32'h0000_1234);
        settle();
        rd(9'h020, d); check("R2 left 16-bit", d, 32'h0000_A5C3);
        rd(9'h024, d); check("R2 right 16-bit", d, 32'h0000_1234);
    endtask

    task automatic t_res24_32();
        logic [31:0] d;
        resync(3'd4, 24);
        send_frame(32'h00C0_FFEE, 32'h0081_2345);
        settle();
        rd(9'h020, d); check("R3 left 24-bit", d, 32'h00C0_FFEE);
        rd(9'h024, d); check("R3 right 24-bit", d, 32'h0081_2345);
        resync(3'd5, 32);
        send_frame(32'hDEAD_BEEF, 32'h8765_4321);
        send_slot(1'b0, 32'd0);
        settle();
        rd(9'h020, d); check("R11 left 32-bit, LSB after ws edge", d, 32'hDEAD_BEEF);
        rd(9'h024, d); check("R3 right 32-bit", d, 32'h8765_4321);
    endtask

    task automatic t_bad_code();
        logic [31:0] d;
        wr(9'h030, 2); wr(9'h030, 3);
        rd(9'h030, d); check("R4 code 3 ignored", d, 2);
        wr(9'h030, 7);
        rd(9'h030, d); check("R4 code 7 ignored", d, 2);
    endtask

    task automatic t_order_avail();
        logic [31:0] d;
        wr(9'h048, 7); wr(9'h03C, 2);
        resync(3'd2, 16);
        for (int k = 0; k < 7; k++) send_frame(pat(k, 16), pat(k + 40, 16));
        settle();
        rd(9'h038, d); check("R6 no data-available at 7 entries", d, 0);
        #1 check("R6 irq low at 7 entries", {31'd0, irq}, 0);
        send_frame(pat(7, 16), pat(47, 16));
        settle();
        rd(9'h038, d); check("R6 data-available at 8 entries", d, 1);
        #1 check("R6 irq with bit 0 unmasked", {31'd0, irq}, 1);
        wr(9'h03C, 3);
        #1 check("R6 irq masked by bit 0", {31'd0, irq}, 0);
        for (int k = 0; k < 8; k++) begin
            rd(9'h020, d); check("R5 left in order", d, pat(k, 16));
            rd(9'h024, d); check("R5 right in order", d, pat(k + 40, 16));
        end
        rd(9'h024, d); check("R5 empty right read", d, 0);
        rd(9'h020, d); check("R5 empty left read", d, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        wr(9'h03C, 1); wr(9'h048, 7);
        resync(3'd2, 16);
        for (int k = 0; k < 9; k++) send_frame(pat(k + 10, 16), pat(k + 60, 16));
        settle();
        rd(9'h038, d); check("R7 overrun and available", d, 3);
        #1 check("R7 irq from overrun", {31'd0, irq}, 1);
        wr(9'h03C, 3);
        #1 check("R7 irq masked by bit 1", {31'd0, irq}, 0);
        for (int k = 0; k < 8; k++) begin
            rd(9'h020, d); check("R7 kept left", d, pat(k + 10, 16));
            rd(9'h024, d); check("R7 kept right", d, pat(k + 60, 16));
        end
        rd(9'h024, d); check("R7 ninth pair dropped", d, 0);
        rd(9'h040, d); check("R8 overrun read value", d, 1);
        rd(9'h038, d); check("R8 overrun cleared", d, 0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        wr(9'h048, 0);
        resync(3'd2, 16);
        for (int k = 0; k < 3; k++) send_frame(pat(k, 16), pat(k + 1, 16));
        settle();
        rd(9'h038, d); check("R9 entries before flush", d, 1);
        wr(9'h010, 1);
        rd(9'h038, d); check("R9 empty after flush", d, 0);
        rd(9'h020, d); check("R9 left after flush", d, 0);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        logic [8:0] addr;
        for (int e = 0; e < 3; e++) begin
            addr = (e == 0) ? 9'h000 : (e == 1) ? 9'h004 : 9'h028;
            resync(3'd2, 16);
            wr(addr, 0);
            send_frame(16'h1111, 16'h2222);
            send_frame(16'h3333, 16'h4444);
            settle();
            rd(9'h038, d); check("R10 nothing captured with an enable off", d, 0);
            rd(9'h024, d); check("R10 right buffer empty", d, 0);
            wr(addr, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 200000 cycles, expected completion earlier");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_res16();
        t_res24_32();
        t_bad_code();
        t_order_avail();
        t_overrun();
        t_flush();
        t_enables();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule